// File: doc/BRIEF.md
# Gamma Coefficient Table Register Port

This block is the register-side store for a piecewise-linear gamma curve. It keeps three coefficient tables, one each for red, green and blue, of 64 entries. Each entry holds a 12-bit slope and a 12-bit offset. A curve evaluator elsewhere in the display pipe reads all three tables at once through independent combinational read ports. One more register carries the gamma enable bit, and clearing it lets pixels bypass the curve.

Software loads the tables through a write-only strobe bus of valid, address and data. It first writes an address register to set the starting table entry and a three-bit channel mask. It then streams data words. Each data word is written into every selected channel table at the current entry, and the entry pointer moves on by one after each word. A full curve is one address write followed by 64 data writes. Setting all three mask bits loads the same curve into every channel in a single pass.

Top module: `gamma_coef_port`

## Requirements
- R1: On synchronous reset every entry of all three tables reads as slope 0 and offset 0, gamma_en is 0, the entry pointer is 0 and the channel mask is 0.
- R2: A write to byte offset 0x30 loads the entry pointer from data bits 5:0. It also loads the channel mask from bits 18:16, where bit 16 selects red, bit 17 green and bit 18 blue. Both take effect on the next clock.
- R3: A write to byte offset 0x34 stores data bits 27:16 as the slope and bits 11:0 as the offset into every selected table at the current entry. The new value is visible on the read ports after the clock edge. Data bits 31:28 and 15:12 are ignored.
- R4: Every data write advances the entry pointer by one, and the pointer wraps from 63 to 0.
- R5: A data write made while the channel mask is zero changes no table entry but still advances the entry pointer.
- R6: A table whose mask bit is clear keeps all of its entries through data writes aimed at the other channels.
- R7: A write to byte offset 0x00 sets gamma_en to data bit 0, and all other data bits are ignored. gamma_en keeps its value at all other times.
- R8: A strobe with wr_valid low, or a write to any other offset, changes no table, pointer, mask or enable.
- R9: The three read lanes are independent. Lane c of rd_slope and rd_ofs (bits 12c+11:12c) shows the entry chosen by lane c of rd_idx (bits 6c+5:6c) in the same cycle, where lane 0 is red, lane 1 green and lane 2 blue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte offset of the written register |
| wr_data | input | 32 | Write data |
| rd_idx | input | 18 | Three 6-bit read entry indices, lane 0 red |
| rd_slope | output | 36 | Three 12-bit slopes read from the tables |
| rd_ofs | output | 36 | Three 12-bit offsets read from the tables |
| gamma_en | output | 1 | Gamma curve enable |

## Verification
The assertions check the following on every cycle. The pointer and mask reload on an address write. The pointer steps and wraps on each data write, including data writes with an empty mask. The enable changes only on its own register. Stray writes leave the control state alone. The read lanes stay steady while no data write lands. Only the bench scenarios can show that a word lands in exactly the selected tables at the right entries with the ignored bits dropped, and that the unselected channels keep their contents. To show this, a behavioural model is compared against every read lane on every clock while the read indices sweep the whole table.

// File: rtl/gamma_tbl_pkg.sv
package gamma_tbl_pkg;

    localparam int TBL_ENTRIES = 64;
    localparam int CH_N        = 3;
    localparam int COEF_W      = 12;
    localparam int BUS_AW      = 8;
    localparam int BUS_DW      = 32;

    localparam logic [BUS_AW-1:0] OFS_FUNC = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_ADDR = 8'h30;
    localparam logic [BUS_AW-1:0] OFS_DATA = 8'h34;

    localparam int MASK_LSB  = 16;
    localparam int SLOPE_LSB = 16;
    localparam int OFFS_LSB  = 0;
    localparam int EN_BIT    = 0;

    typedef struct packed {
        logic [COEF_W-1:0] slope;
        logic [COEF_W-1:0] offs;
    } coef_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_FUNC,
        OP_ADDR,
        OP_DATA
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [BUS_DW-1:0] data;
    } bus_op_t;

    function automatic coef_t word_to_coef(input logic [BUS_DW-1:0] w);
        coef_t c;
        c.slope = w[SLOPE_LSB +: COEF_W];
        c.offs  = w[OFFS_LSB +: COEF_W];
        return c;
    endfunction

endpackage

// File: rtl/gamma_reg_decode.sv
module gamma_reg_decode
    import gamma_tbl_pkg::*;
(
    input  logic              wr_valid,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    output bus_op_t           op,
    output coef_t             coef
);

    always_comb begin
        op.data = wr_data;
        op.kind = OP_NONE;
        if (wr_valid) begin
            unique case (wr_addr)
                OFS_FUNC: op.kind = OP_FUNC;
                OFS_ADDR: op.kind = OP_ADDR;
                OFS_DATA: op.kind = OP_DATA;
                default:  op.kind = OP_NONE;
            endcase
        end
    end

    assign coef = word_to_coef(wr_data);

endmodule

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl
    import gamma_tbl_pkg::*;
#(
    parameter int N_ENT = TBL_ENTRIES,
    localparam int IW   = $clog2(N_ENT)
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_op_t         op,
    output logic [IW-1:0]   cur_idx,
    output logic [CH_N-1:0] cur_mask,
    output logic [CH_N-1:0] ch_we
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N_ENT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx  <= '0;
            cur_mask <= '0;
        end else begin
            case (op.kind)
                OP_ADDR: begin
                    cur_idx  <= op.data[IW-1:0];
                    cur_mask <= op.data[MASK_LSB +: CH_N];
                end
                OP_DATA: begin
                    cur_idx <= (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ch_we = (op.kind == OP_DATA) ? cur_mask : '0;

endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
    import gamma_tbl_pkg::*;
#(
    parameter int N_ENT = TBL_ENTRIES,
    localparam int IW   = $clog2(N_ENT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  coef_t         wcoef,
    input  logic [IW-1:0] ridx,
    output coef_t         rcoef
);

    coef_t mem [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wcoef;
        end
    end

    assign rcoef = mem[ridx];

endmodule

// File: rtl/gamma_func_reg.sv
module gamma_func_reg
    import gamma_tbl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    output logic    enable
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
        end else if (op.kind == OP_FUNC) begin
            enable <= op.data[EN_BIT];
        end
    end

endmodule

// File: rtl/gamma_coef_port.sv
module gamma_coef_port
    import gamma_tbl_pkg::*;
#(
    parameter int N_ENT = TBL_ENTRIES,
    localparam int IW   = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_valid,
    input  logic [BUS_AW-1:0]      wr_addr,
    input  logic [BUS_DW-1:0]      wr_data,
    input  logic [CH_N*IW-1:0]     rd_idx,
    output logic [CH_N*COEF_W-1:0] rd_slope,
    output logic [CH_N*COEF_W-1:0] rd_ofs,
    output logic                   gamma_en
);

    bus_op_t         op;
    coef_t           wcoef;
    logic [IW-1:0]   cur_idx;
    logic [CH_N-1:0] cur_mask;
    logic [CH_N-1:0] ch_we;

    gamma_reg_decode u_dec (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .op       (op),
        .coef     (wcoef)
    );

    gamma_addr_ctrl #(.N_ENT(N_ENT)) u_actl (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .cur_idx  (cur_idx),
        .cur_mask (cur_mask),
        .ch_we    (ch_we)
    );

    gamma_func_reg u_func (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .enable (gamma_en)
    );

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        coef_t rc;

        gamma_coef_bank #(.N_ENT(N_ENT)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (ch_we[ch]),
            .widx  (cur_idx),
            .wcoef (wcoef),
            .ridx  (rd_idx[ch*IW +: IW]),
            .rcoef (rc)
        );

        assign rd_slope[ch*COEF_W +: COEF_W] = rc.slope;
        assign rd_ofs[ch*COEF_W +: COEF_W]   = rc.offs;
    end

endmodule

// File: rtl/gamma_coef_port_chk.sv
module gamma_coef_port_chk
    import gamma_tbl_pkg::*;
#(
    parameter int N_ENT = TBL_ENTRIES,
    localparam int IW   = $clog2(N_ENT)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_valid,
    input logic [BUS_AW-1:0]      wr_addr,
    input logic [BUS_DW-1:0]      wr_data,
    input logic [CH_N*IW-1:0]     rd_idx,
    input logic [CH_N*COEF_W-1:0] rd_slope,
    input logic [CH_N*COEF_W-1:0] rd_ofs,
    input logic                   gamma_en,
    input logic [IW-1:0]          cur_idx,
    input logic [CH_N-1:0]        cur_mask
);

    logic hit_func, hit_addr, hit_data, stray;
    assign hit_func = wr_valid && (wr_addr == OFS_FUNC);
    assign hit_addr = wr_valid && (wr_addr == OFS_ADDR);
    assign hit_data = wr_valid && (wr_addr == OFS_DATA);
    assign stray    = !hit_func && !hit_addr && !hit_data;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!gamma_en && cur_idx == '0 && cur_mask == '0)); // R1

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit_addr |=> (cur_idx == $past(wr_data[IW-1:0])
                      && cur_mask == $past(wr_data[MASK_LSB +: CH_N]))); // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        hit_data |=> (cur_idx == IW'($past(cur_idx) + 1'b1) && $stable(cur_mask))); // R4

    AST_EMPTY_MASK_STEP: assert property (@(posedge clk) disable iff (rst)
        (hit_data && cur_mask == '0) |=> (cur_idx != $past(cur_idx))); // R5

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit_func |=> (gamma_en == $past(wr_data[EN_BIT]))); // R7

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit_func |=> $stable(gamma_en)); // R7

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        stray |=> ($stable(cur_idx) && $stable(cur_mask) && $stable(gamma_en))); // R8

    AST_READ_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!$past(hit_data) && $stable(rd_idx)) |-> ($stable(rd_slope) && $stable(rd_ofs))); // R9

endmodule

bind gamma_coef_port gamma_coef_port_chk #(.N_ENT(N_ENT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_slope (rd_slope),
    .rd_ofs   (rd_ofs),
    .gamma_en (gamma_en),
    .cur_idx  (cur_idx),
    .cur_mask (cur_mask)
);

// File: tb/gamma_coef_port_test.sv
module gamma_coef_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic [17:0] rd_idx = '0;
    logic [35:0] rd_slope, rd_ofs;
    logic        gamma_en;

    always #4 clk = ~clk;

    gamma_coef_port uut (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_slope (rd_slope),
        .rd_ofs   (rd_ofs),
        .gamma_en (gamma_en)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int m_slope [3][64];
    int m_ofs   [3][64];
    int m_idx, m_mask, m_en;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 3; c++)
                for (int e = 0; e < 64; e++) begin
                    m_slope[c][e] = 0;
                    m_ofs[c][e]   = 0;
                end
            m_idx = 0; m_mask = 0; m_en = 0;
        end else if (wr_valid) begin
            if (wr_addr == 8'h30) begin
                m_idx  = int'(wr_data[5:0]);
                m_mask = int'(wr_data[18:16]);
            end else if (wr_addr == 8'h34) begin
                for (int c = 0; c < 3; c++)
                    if (((m_mask >> c) & 1) == 1) begin
                        m_slope[c][m_idx] = int'(wr_data[27:16]);
                        m_ofs[c][m_idx]   = int'(wr_data[11:0]);
                    end
                m_idx = (m_idx + 1) % 64;
            end else if (wr_addr == 8'h00) begin
                m_en = int'(wr_data[0]);
            end
        end
    end

    // read index sweep: each lane walks the table with its own phase (R9)
    int sweep = 0;
    always @(negedge clk) begin
        sweep <= (sweep + 1) % 64;
        rd_idx[5:0]   <= 6'(sweep);
        rd_idx[11:6]  <= 6'((sweep + 21) % 64);
        rd_idx[17:12] <= 6'((sweep + 42) % 64);
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the edges
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            check(tag, "gamma_en", int'(gamma_en), m_en);
            for (int c = 0; c < 3; c++) begin
                int e;
                e = int'(rd_idx[c*6 +: 6]);
                check(tag, $sformatf("lane%0d slope[%0d]", c, e),
                      int'(rd_slope[c*12 +: 12]), m_slope[c][e]);
                check(tag, $sformatf("lane%0d offset[%0d]", c, e),
                      int'(rd_ofs[c*12 +: 12]), m_ofs[c][e]);
            end
        end
    end

    task automatic bw(input logic [7:0] a, input logic [31:0] d, input logic v = 1'b1);
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] word(input int k);
        return {4'hF, 12'(k * 37 + 1), 4'hA, 12'(k * 91 + 5)};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state swept over every entry of every lane
        tag = "R1";
        #2 check("R1", "gamma_en after reset", int'(gamma_en), 0);
        idle(66);

        // R7: enable set, then a word with bit 0 clear and other bits set
        tag = "R7";
        bw(8'h00, 32'h0000_0001);
        idle(2);
        #2 check("R7", "enable set", int'(gamma_en), 1);
        bw(8'h00, 32'hFFFF_FFFE);
        idle(2);
        #2 check("R7", "enable cleared", int'(gamma_en), 0);
        bw(8'h00, 32'h0000_0001);

        // R2/R3: all channels, full 64-entry load from entry 0, ignored bits set
        tag = "R3";
        bw(8'h30, 32'h0007_0000);
        for (int k = 0; k < 64; k++) bw(8'h34, word(k));
        idle(66);

        // R4: one more word wraps to entry 0
        tag = "R4";
        bw(8'h34, 32'h0ABC_0123);
        idle(2);
        // R4, R6: green only from entry 60 across the wrap
        bw(8'h30, 32'h0002_003C);
        for (int k = 0; k < 8; k++) bw(8'h34, word(200 + k));
        tag = "R6";
        idle(66);

        // R2: blue only, non-zero start entry
        tag = "R2";
        bw(8'h30, 32'h0004_0011);
        for (int k = 0; k < 4; k++) bw(8'h34, word(300 + k));
        idle(66);

        // R5: empty mask leaves every table unchanged
        tag = "R5";
        bw(8'h30, 32'h0000_0005);
        for (int k = 0; k < 5; k++) bw(8'h34, 32'h0FFF_0FFF);
        idle(66);

        // R8: stray offsets and unasserted strobes
        tag = "R8";
        bw(8'h38, 32'h0007_0000);
        bw(8'h04, 32'h0000_0000);
        bw(8'h34, 32'h0555_0555, 1'b0);
        bw(8'h00, 32'h0000_0000, 1'b0);
        bw(8'h31, 32'h0FFF_0FFF);
        idle(2);
        #2 check("R8", "enable held", int'(gamma_en), 1);
        idle(66);

        // R9: red and green mixed load, lanes read with independent phases
        tag = "R9";
        bw(8'h30, 32'h0003_0020);
        for (int k = 0; k < 6; k++) bw(8'h34, word(400 + k));
        idle(66);

        // R1: reset again clears everything
        tag = "R1";
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(66);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule